// File: doc/BRIEF.md
# Dual-Processor Mailbox Flag Controller

This block lets two processors pass doorbell-style notifications over a set of channels. Each processor owns a small register window. In that window it can raise an "occupied" flag on any channel to say it has posted a message. It can also acknowledge a channel, which drops the flag the other processor raised on that channel.

The block sits on one synchronous register bus shared by both processors. A request carries an address, a write strobe, write data and a one-bit select naming the processor that issues it. Reads are combinational from the current flag state. Writes take effect on the next rising clock edge.

A global configuration word tells software how many channels exist. A sender treats a channel as busy while its own flag is still up. It posts again only after the peer has acknowledged.

Top module: `dpmbx_flag_ctrl`

## Requirements
- R1: After reset every occupied flag is 0, so both status registers read 0.
- R2: A read of address 0x3F0 returns the channel count NUM_CH in bits 7:0, with bits 31:8 at 0.
- R3: Processor p (0 or 1) owns a window at base p×0x10. Its command register sits at base+0x8, is write-only and reads 0. Its status register sits at base+0xC.
- R4: When processor p writes 1 to bit 16+n of its own command register, its occupied flag n is set, and status bit n of its window reads 1 from the next cycle.
- R5: When processor p writes 1 to bit n of its own command register, the peer's occupied flag n is cleared. Processor p's own flags are left as they were.
- R6: A 0 in any bit of a command write leaves the matching flag unchanged. Flags hold their value while nothing writes them.
- R7: A command write is accepted only when the processor select equals the owner index of the addressed window; any other command write changes no flag.
- R8: Command bits n and 16+n with n ≥ NUM_CH are ignored. Status bits at and above NUM_CH read 0.
- R9: Reads of any unmapped address, or of a command register, return 0. Writes to status, configuration or unmapped addresses change no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W (10) | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_cpu | input | 1 | Index of the processor issuing the access |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
The bench builds the block with its default of six channels and a ten-bit address. At that width the configuration word at 0x3F0 is reachable. Six channels also leaves command bits 6..15 and 22..31 out of range, so writes that flood those bits show whether they leak into the flags. A six-channel status word also makes any stray high bit in a read visible. Both processors post, acknowledge and attempt cross-window writes against one shared flag state, so ownership and peer-clear paths are exercised in both directions.

// File: rtl/dpmbx_pkg.sv
package dpmbx_pkg;
    localparam int NUM_PROC    = 2;
    localparam int DATA_W      = 32;
    localparam int MAX_CH      = 16;
    localparam int SET_SHIFT   = 16;
    localparam int WIN_STRIDE  = 'h010;
    localparam int CMD_OFF     = 'h008;
    localparam int STAT_OFF    = 'h00C;
    localparam int CFG_ADDR    = 'h3F0;
    localparam int CFG_CNT_W   = 8;

    typedef struct packed {
        logic [NUM_PROC-1:0] cmd;
        logic [NUM_PROC-1:0] stat;
        logic                cfg;
        logic                any;
    } dec_hits_t;
endpackage

// File: rtl/dpmbx_decode.sv
module dpmbx_decode
    import dpmbx_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_hits_t         hits
);
    logic [NUM_PROC-1:0] cmd_hit;
    logic [NUM_PROC-1:0] stat_hit;
    logic                cfg_hit;

    for (genvar p = 0; p < NUM_PROC; p++) begin : g_win
        localparam int CMD_A  = p * WIN_STRIDE + CMD_OFF;
        localparam int STAT_A = p * WIN_STRIDE + STAT_OFF;
        assign cmd_hit[p]  = (addr == ADDR_W'(CMD_A));
        assign stat_hit[p] = (addr == ADDR_W'(STAT_A));
    end

    assign cfg_hit = (addr == ADDR_W'(CFG_ADDR));

    always_comb begin
        hits.cmd  = cmd_hit;
        hits.stat = stat_hit;
        hits.cfg  = cfg_hit;
        hits.any  = cfg_hit | (|cmd_hit) | (|stat_hit);
    end
endmodule

// File: rtl/dpmbx_flag_bank.sv
module dpmbx_flag_bank #(
    parameter int NUM_CH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] set_vec,
    input  logic [NUM_CH-1:0] clr_vec,
    output logic [NUM_CH-1:0] flags
);
    // Per-channel flag; a clear wins over a set aimed at the same flag.
    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                flags[n] <= 1'b0;
            else if (clr_vec[n])
                flags[n] <= 1'b0;
            else if (set_vec[n])
                flags[n] <= 1'b1;
        end
    end

    logic [NUM_CH-1:0] set_only;
    assign set_only = set_vec & ~clr_vec;

    assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (set_only != '0) |=> ((flags & $past(set_only)) == $past(set_only)));

    assert_flag_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec != '0) |=> ((flags & $past(clr_vec)) == '0));

    assert_flag_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec == '0 && clr_vec == '0) |=> $stable(flags));
endmodule

// File: rtl/dpmbx_read_mux.sv
module dpmbx_read_mux
    import dpmbx_pkg::*;
#(
    parameter int NUM_CH = 6
) (
    input  dec_hits_t                        hits,
    input  logic [NUM_PROC-1:0][NUM_CH-1:0]  occ,
    output logic [DATA_W-1:0]                rdata
);
    localparam logic [DATA_W-1:0] CFG_WORD =
        DATA_W'(NUM_CH) & DATA_W'((1 << CFG_CNT_W) - 1);

    always_comb begin
        rdata = '0;
        if (hits.cfg)
            rdata = CFG_WORD;
        for (int p = 0; p < NUM_PROC; p++) begin
            if (hits.stat[p])
                rdata = DATA_W'(occ[p]);
        end
    end
endmodule

// File: rtl/dpmbx_flag_ctrl.sv
module dpmbx_flag_ctrl
    import dpmbx_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_cpu,
    output logic [31:0]       bus_rdata
);
    localparam logic [DATA_W-1:0] LIVE_MASK =
        DATA_W'((1 << NUM_CH) - 1) | (DATA_W'((1 << NUM_CH) - 1) << SET_SHIFT);

    dec_hits_t                        hits;
    logic [NUM_PROC-1:0]              wr_own;
    logic [NUM_PROC-1:0][NUM_CH-1:0]  occ;
    logic [NUM_CH-1:0]                raise_bits;
    logic [NUM_CH-1:0]                ack_bits;

    dpmbx_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (bus_addr),
        .hits (hits)
    );

    assign raise_bits = bus_wdata[SET_SHIFT +: NUM_CH];
    assign ack_bits   = bus_wdata[NUM_CH-1:0];

    for (genvar p = 0; p < NUM_PROC; p++) begin : g_proc
        localparam int PEER = NUM_PROC - 1 - p;
        logic [NUM_CH-1:0] set_v;
        logic [NUM_CH-1:0] clr_v;

        // Only the owner of a window may issue its commands.
        assign wr_own[p] = bus_wr & hits.cmd[p] & (bus_cpu == 1'(p));
        assign set_v     = wr_own[p]    ? raise_bits : '0;
        assign clr_v     = wr_own[PEER] ? ack_bits   : '0;

        dpmbx_flag_bank #(.NUM_CH(NUM_CH)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_vec (set_v),
            .clr_vec (clr_v),
            .flags   (occ[p])
        );
    end

    dpmbx_read_mux #(.NUM_CH(NUM_CH)) u_rmux (
        .hits  (hits),
        .occ   (occ),
        .rdata (bus_rdata)
    );

    assert_cfg_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hits.cfg |-> (bus_rdata == 32'(NUM_CH)));

    assert_foreign_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (hits.cmd != '0) && !hits.cmd[bus_cpu]) |=> $stable(occ));

    assert_upper_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && ((bus_wdata & LIVE_MASK) == '0)) |=> $stable(occ));

    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !hits.any |-> (bus_rdata == '0));

    assert_noncmd_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (hits.cmd == '0)) |=> $stable(occ));
endmodule

// File: tb/dpmbx_flag_ctrl_bench.sv
module dpmbx_flag_ctrl_bench;
    localparam int NCH = 6;
    localparam int AW  = 10;

    typedef struct {
        logic [AW-1:0] addr;
        logic [31:0]   exp;
        string         tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_cpu = 1'b0;
    logic [31:0]   bus_rdata;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    item_t sb[$];
    logic [NCH-1:0] m_occ [2];

    always #2 clk = ~clk;

    dpmbx_flag_ctrl #(.NUM_CH(NCH), .ADDR_W(AW)) u_dpmbx_flag_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_cpu   (bus_cpu),
        .bus_rdata (bus_rdata)
    );

    function automatic logic [31:0] model_read(logic [AW-1:0] a);
        if (a == AW'('h3F0)) return 32'(NCH);
        if (a == AW'('h00C)) return 32'(m_occ[0]);
        if (a == AW'('h01C)) return 32'(m_occ[1]);
        return 32'h0;
    endfunction

    task automatic model_write(logic cpu, logic [AW-1:0] a, logic [31:0] d);
        if (a == AW'(32'(cpu) * 'h10 + 'h8)) begin
            m_occ[cpu]  = m_occ[cpu] | d[16 +: NCH];
            m_occ[!cpu] = m_occ[!cpu] & ~d[NCH-1:0];
        end
    endtask

    task automatic do_write(logic cpu, logic [AW-1:0] a, logic [31:0] d);
        @(posedge clk); #1;
        bus_cpu = cpu; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        model_write(cpu, a, d);
    endtask

    task automatic do_read(logic [AW-1:0] a, string tag);
        item_t it;
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_addr = a;
        it.addr = a; it.exp = model_read(a); it.tag = tag;
        sb.push_back(it);
    endtask

    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (bus_rdata !== it.exp) begin
                errors++;
                $display("FAIL %s addr=0x%03h actual=0x%08h expected=0x%08h",
                         it.tag, it.addr, bus_rdata, it.exp);
            end
        end
    end

    initial begin
        m_occ[0] = '0; m_occ[1] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        do_read('h00C, "R1 status0 after reset");
        do_read('h01C, "R1 status1 after reset");
        do_read('h3F0, "R2 channel count");
        do_read('h008, "R3 command reg reads 0");
        // R4: posting on channels 0 and 3 from processor 0
        do_write(1'b0, 'h008, 32'h0009_0000);
        do_read('h00C, "R4 status0 after post");
        do_read('h01C, "R3 window1 untouched");
        do_write(1'b1, 'h018, 32'h0028_0000);
        do_read('h01C, "R4 status1 after post");
        do_read('h018, "R3 command reg1 reads 0");
        // R5: processor 1 acknowledges channel 0 of processor 0
        do_write(1'b1, 'h018, 32'h0000_0001);
        do_read('h00C, "R5 peer flag cleared");
        do_read('h01C, "R5 own flags kept");
        do_write(1'b0, 'h008, 32'h0000_0000);
        do_read('h00C, "R6 zero write status0");
        do_read('h01C, "R6 zero write status1");
        // R7: cross-window command writes
        do_write(1'b0, 'h018, 32'h003F_003F);
        do_write(1'b1, 'h008, 32'h003F_003F);
        do_read('h00C, "R7 foreign write status0");
        do_read('h01C, "R7 foreign write status1");
        // R8: out-of-range bits
        do_write(1'b0, 'h008, 32'hFFC0_FFC0);
        do_read('h00C, "R8 high bits status0");
        do_read('h01C, "R8 high bits status1");
        do_write(1'b1, 'h018, 32'hFFFF_0000);
        do_read('h01C, "R8 full post reads 6 bits");
        // R9: writes to non-command addresses, unmapped reads
        do_write(1'b0, 'h00C, 32'hFFFF_FFFF);
        do_write(1'b1, 'h3F0, 32'hFFFF_FFFF);
        do_write(1'b0, 'h004, 32'hFFFF_FFFF);
        do_read('h00C, "R9 status0 after stray writes");
        do_read('h01C, "R9 status1 after stray writes");
        do_read('h004, "R9 unmapped 0x004");
        do_read('h100, "R9 unmapped 0x100");
        do_read('h3F4, "R9 unmapped 0x3F4");
        // R5: processor 0 acknowledges everything of processor 1
        do_write(1'b0, 'h008, 32'h0000_003F);
        do_read('h01C, "R5 peer fully acked");
        do_read('h00C, "R5 acker flags kept");
        do_read('h3F0, "R2 channel count again");
        @(posedge clk); @(posedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule